// File: doc/BRIEF.md
# Debug Halt and Restart Controller

This block manages, for each core in a cluster, the passage into and out of a halted debug state. An external debugger raises a level-held halt request. If invasive debug is enabled for that core, the controller moves through a fixed-length entry phase while the pipeline quiesces. It then reports the halt through an acknowledge line. A second indication, halted-and-drained, also asserts once the core reports that every memory access issued before the halt has finished.

Leaving the halted state is a four-phase handshake on a restart request and a restart-complete line. Restart-complete is high in normal operation and while halted. It drops once a restart is seen. It rises again, with the core back in normal state, once the requester releases restart. Each core also exposes a power-down-inhibit flag, which is taken from bit 0 of its debug power-control register value.

One controller instance is generated per core. The cores share only the clock and the reset.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset every core is in normal state with restarted_o high, halt_ack_o low and halted_done_o low.
- R2: With dbg_en_i high, a halt request sampled in normal state makes halt_ack_o rise exactly ENTRY_CYCLES+1 clock edges after the first edge that samples it (4 edges at the default of 3).
- R3: While dbg_en_i is low, a halt request in normal state is ignored: halt_ack_o stays low and restarted_o stays high.
- R4: halted_done_o is high exactly when the core is halted and mem_drained_i is high, and it follows mem_drained_i combinationally while halted.
- R5: A restart request sampled while halted clears restarted_o, halt_ack_o and halted_done_o on that same edge, and restarted_o stays low while the request is held.
- R6: Restarted_o rises on the edge that samples restart_req_i low in the restarting state, and the core is then in normal state.
- R7: A halt request held during the restarting state has no effect until the handshake ends. If it is still high, a new entry starts on the next edge, so halt_ack_o rises ENTRY_CYCLES+2 edges after the releasing edge.
- R8: Each core's handshake is independent: activity on one core's inputs never changes another core's outputs.
- R9: no_pwrdn_o[c] equals bit 0 of core c's field pwr_ctl_i[c*PWR_W +: PWR_W], combinationally.
- R10: Once the entry phase has started, it completes even if the halt request or dbg_en_i drops before the acknowledge.
- R11: A restart request in normal state is ignored: restarted_o stays high and halt_ack_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_en_i | input | N_CORES | Per-core invasive debug enable |
| halt_req_i | input | N_CORES | Per-core level-held halt request |
| restart_req_i | input | N_CORES | Per-core restart request, held until restarted_o falls |
| mem_drained_i | input | N_CORES | Per-core flag that prior memory accesses have completed |
| pwr_ctl_i | input | N_CORES*PWR_W | Per-core debug power-control register values |
| halt_ack_o | output | N_CORES | Core is halted after an external request |
| halted_done_o | output | N_CORES | Core is halted and drained |
| restarted_o | output | N_CORES | Restart-complete side of the exit handshake |
| no_pwrdn_o | output | N_CORES | Power-down inhibit, bit 0 of the power-control value |

## Verification
The bench checks the exact edge on which the acknowledge rises. A controller that skipped or added an entry cycle would acknowledge one edge early or late. It drops the request and the enable in the middle of the entry phase, which would catch a design that aborts the entry. It holds a halt request across the whole restart handshake, which would expose a design that jumps from restarting straight into a new entry, or that loses the held request. Exhaustive sweeps over the power-control values and the drained flag would catch a wrong bit selection, a lane swap between cores, or a done output that ignores the drained flag.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_HALTING    = 2'd1,
    ST_HALTED     = 2'd2,
    ST_RESTARTING = 2'd3
  } dbg_state_e;
endpackage

// File: rtl/dbg_entry_timer.sv
module dbg_entry_timer #(
  parameter int unsigned CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam int unsigned LAST = (CYCLES > 0) ? CYCLES - 1 : 0;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q != CW'(LAST)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(LAST));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LAST)); // R2
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R2
endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
  import dbg_halt_pkg::*;
#(
  parameter int unsigned ENTRY_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbg_en_i,
  input  logic halt_req_i,
  input  logic restart_req_i,
  input  logic mem_drained_i,
  output logic halt_ack_o,
  output logic halted_done_o,
  output logic restarted_o
);
  dbg_state_e st_q, st_d;
  logic       entry_done;
  logic       in_entry;

  assign in_entry = (st_q == ST_HALTING);

  dbg_entry_timer #(.CYCLES(ENTRY_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (in_entry),
    .expired_o (entry_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL:     if (halt_req_i && dbg_en_i) st_d = ST_HALTING;
      ST_HALTING:    if (entry_done)             st_d = ST_HALTED;   // entry cannot be aborted
      ST_HALTED:     if (restart_req_i)          st_d = ST_RESTARTING;
      ST_RESTARTING: if (!restart_req_i)         st_d = ST_NORMAL;   // halt held off here
      default:                                   st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_NORMAL;
    else         st_q <= st_d;
  end

  assign halt_ack_o    = (st_q == ST_HALTED);
  assign halted_done_o = (st_q == ST_HALTED) && mem_drained_i;
  assign restarted_o   = (st_q != ST_RESTARTING);

  AST_ACK_AFTER_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_ack_o) |-> $past(entry_done)); // R2
  AST_DISABLED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NORMAL && !dbg_en_i) |=> !halt_ack_o && restarted_o); // R3
  AST_DONE_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_done_o |-> halt_ack_o); // R4
  AST_RESTART_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(restarted_o) |-> $past(restart_req_i) && $past(halt_ack_o) && !halt_ack_o); // R5
  AST_RESTART_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restarted_o) |-> !$past(restart_req_i)); // R6
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RESTARTING && restart_req_i) |=> !halt_ack_o && !restarted_o); // R7
  AST_ENTRY_COMMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HALTING) |=> (st_q == ST_HALTING || st_q == ST_HALTED)); // R10
  AST_NORMAL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NORMAL) |=> restarted_o); // R11
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl #(
  parameter int unsigned N_CORES      = 2,
  parameter int unsigned ENTRY_CYCLES = 3,
  parameter int unsigned PWR_W        = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CORES-1:0]         dbg_en_i,
  input  logic [N_CORES-1:0]         halt_req_i,
  input  logic [N_CORES-1:0]         restart_req_i,
  input  logic [N_CORES-1:0]         mem_drained_i,
  input  logic [N_CORES*PWR_W-1:0]   pwr_ctl_i,
  output logic [N_CORES-1:0]         halt_ack_o,
  output logic [N_CORES-1:0]         halted_done_o,
  output logic [N_CORES-1:0]         restarted_o,
  output logic [N_CORES-1:0]         no_pwrdn_o
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    dbg_halt_fsm #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_fsm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .dbg_en_i      (dbg_en_i[c]),
      .halt_req_i    (halt_req_i[c]),
      .restart_req_i (restart_req_i[c]),
      .mem_drained_i (mem_drained_i[c]),
      .halt_ack_o    (halt_ack_o[c]),
      .halted_done_o (halted_done_o[c]),
      .restarted_o   (restarted_o[c])
    );

    assign no_pwrdn_o[c] = pwr_ctl_i[c*PWR_W];

    AST_PWR_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(pwr_ctl_i[c*PWR_W]) |-> $stable(no_pwrdn_o[c])); // R9
  end
endmodule

// File: tb/dbg_halt_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_tb_top;
  localparam int NC = 2;
  localparam int E  = 3;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] en = '0, req = '0, rst_req = '0, drained = '0;
  logic [NC*PW-1:0] pwr = '0;
  logic [NC-1:0] ack, done, restarted, nopd;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbg_halt_ctrl #(.N_CORES(NC), .ENTRY_CYCLES(E), .PWR_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dbg_en_i(en), .halt_req_i(req),
    .restart_req_i(rst_req), .mem_drained_i(drained), .pwr_ctl_i(pwr),
    .halt_ack_o(ack), .halted_done_o(done), .restarted_o(restarted),
    .no_pwrdn_o(nopd));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  // Enter halt on core c with exact-edge checks; other core must stay idle.
  task automatic halt_core(input int c);
    en[c] = 1'b1; req[c] = 1'b1;
    for (int k = 1; k <= E + 1; k++) begin
      tick();
      chk("R2", 32'(ack[c]), 32'(k == E + 1));
      chk("R8", 32'(ack[1-c]), 32'd0);
    end
    req[c] = 1'b0;
  endtask

  task automatic restart_core(input int c);
    drained[c] = 1'b1;
    rst_req[c] = 1'b1;
    tick();
    chk("R5", {29'd0, restarted[c], ack[c], done[c]}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5", 32'(restarted[c]), 32'd0);
    end
    rst_req[c] = 1'b0;
    tick();
    chk("R6", {30'd0, restarted[c], ack[c]}, 32'b10);
    chk("R8", 32'(restarted[1-c]), 32'd1);
    drained[c] = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    chk("R1", {26'd0, ack, done, restarted}, {26'd0, 2'b00, 2'b00, 2'b11});
    rst_n = 1'b1;
    tick();
    chk("R1", {26'd0, ack, done, restarted}, {26'd0, 2'b00, 2'b00, 2'b11});

    // R9: exhaustive sweep of both power-control fields
    for (int v = 0; v < 256; v++) begin
      pwr = 8'(v);
      #0.5;
      chk("R9", 32'(nopd), 32'({v[4], v[0]}));
    end

    // R3: requests with enable low
    en = '0; req = 2'b11;
    for (int k = 0; k < 8; k++) begin
      tick();
      chk("R3", {28'd0, ack, restarted}, {28'd0, 2'b00, 2'b11});
    end
    req = '0;

    // R11: restart in normal state
    rst_req = 2'b11;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R11", {28'd0, ack, restarted}, {28'd0, 2'b00, 2'b11});
    end
    rst_req = '0;
    tick();

    // Main: each core halts, drained sweep, restarts
    for (int c = 0; c < NC; c++) begin
      halt_core(c);
      for (int d = 0; d < 4; d++) begin
        drained = 2'(d);
        #0.5;
        chk("R4", 32'(done[c]), 32'(drained[c]));
        chk("R8", 32'(done[1-c]), 32'd0);
        tick();
        chk("R4", 32'(ack[c]), 32'd1);
      end
      drained = '0;
      restart_core(c);
      en = '0;
    end

    // R10: request and enable dropped mid-entry
    en[0] = 1'b1; req[0] = 1'b1;
    tick();
    req[0] = 1'b0; en[0] = 1'b0;
    for (int k = 2; k <= E + 1; k++) begin
      tick();
      chk("R10", 32'(ack[0]), 32'(k == E + 1));
    end
    tick();
    chk("R10", 32'(ack[0]), 32'd1);

    // R7: halt held across restart handshake (core 0 is halted)
    en[0] = 1'b1; req[0] = 1'b1; rst_req[0] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R7", {30'd0, ack[0], restarted[0]}, 32'd0);
    end
    rst_req[0] = 1'b0;
    for (int k = 1; k <= E + 2; k++) begin
      tick();
      chk("R7", 32'(ack[0]), 32'(k == E + 2));
      if (k == 1) chk("R6", 32'(restarted[0]), 32'd1);
    end
    req[0] = 1'b0;
    restart_core(0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule